// File: doc/BRIEF.md
# Oscillator Trim Frequency Calibrator

This block tunes an on-chip fast oscillator against a slow reference clock. It runs on the fast clock and watches a reference input through a synchronizer. It counts fast-clock cycles between two successive rising edges of the reference. It then compares the count with an inclusive expected window `[win_lo, win_hi]` and moves a trim code by one step toward the window. The trim code drives the oscillator, so each pass closes the loop by one step.

A start request sets the busy state and launches passes. In interval mode the block repeats measure-and-adjust passes until a pass leaves the trim code unchanged. It then clears busy by itself and, if enabled, raises a completion interrupt one fast-clock cycle wide. In continuous mode it keeps running passes until the stop input clears busy. The reference is normally the subsystem clock divided by 512.

Top module: `osc_trim_cal`

## Requirements
- R1: While reset is held and immediately after it, `busy` is 0, `irq` is 0 and `trim` equals the parameter `TRIM_RST`.
- R2: A `start` pulse while idle, with `stop` low, makes `busy` 1 from the next cycle. The first rising reference edge seen after that only arms the counter.
- R3: The measured count is the number of fast-clock cycles between two successive rising reference edges. A steady reference period of P fast cycles yields a count of exactly P.
- R4: At the end of a pass, a count above `win_hi` lowers `trim` by 1 and a count below `win_lo` raises it by 1. A count inside the window, with both bounds inclusive, keeps `trim`.
- R5: In interval mode (`mode_interval` = 1), passes repeat until a pass leaves `trim` unchanged. `busy` then returns to 0 by itself.
- R6: `trim` saturates at 0 and at 2^TRIM_W-1. A pass that asks to step past a limit leaves `trim` unchanged, so in interval mode it ends the run.
- R7: When an interval run ends with `irq_en` = 1, `irq` is high for exactly one cycle, in the cycle `busy` first reads 0. With `irq_en` = 0 no pulse occurs.
- R8: If the counter reaches its all-ones value before the closing edge, it holds there and the pass is treated as above the window, even when `win_hi` is all ones.
- R9: In continuous mode (`mode_interval` = 0), `busy` never clears by itself and no interrupt is raised. `trim` holds while the count stays inside the window.
- R10: `stop` clears `busy` on the next cycle, takes priority over `start` and over a pending adjustment, keeps `trim`, and raises no interrupt.
- R11: `trim` changes only while busy, and by exactly one step at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| start | input | 1 | Start request pulse |
| stop | input | 1 | Stop request, clears busy |
| mode_interval | input | 1 | 1: interval (self-stopping), 0: continuous |
| irq_en | input | 1 | Completion interrupt enable |
| win_lo | input | CNT_W | Lower bound of expected count, inclusive |
| win_hi | input | CNT_W | Upper bound of expected count, inclusive |
| busy | output | 1 | Calibration running |
| trim | output | TRIM_W | Oscillator trim code |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with `CNT_W` = 8, `TRIM_W` = 7 and `TRIM_RST` = 64. A behavioural oscillator model sets each reference period to 100 + trim fast cycles, plus an optional slowdown. With an 8-bit counter, a slowed reference overflows the counter in a few hundred cycles, so the counter-saturation path can be reached. The 7-bit trim lets runs reach both limits, 0 and 127, within the cycle budget. Converged trim values are predicted from the window and the model period, so exact counting is checked through the final code.

// File: rtl/osc_trim_cal.sv
module osc_trim_cal #(
  parameter int CNT_W    = 20,
  parameter int TRIM_W   = 7,
  parameter int TRIM_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              start,
  input  logic              stop,
  input  logic              mode_interval,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  win_lo,
  input  logic [CNT_W-1:0]  win_hi,
  output logic              busy,
  output logic [TRIM_W-1:0] trim,
  output logic              irq
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_MEAS, S_ADJ} st_t;
  st_t st;

  logic [2:0]       ref_sh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[1:0], ref_clk};

  wire ref_rise = ref_sh[1] & ~ref_sh[2];
  wire cnt_sat  = (cnt == CNT_MAX);
  wire above    = cnt_sat || (cnt > win_hi);
  wire below    = !above && (cnt < win_lo);
  wire step_dn  = above && (trim != '0);
  wire step_up  = below && (trim != TRIM_MAX);
  wire moved    = step_dn || step_up;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      trim <= TRIM_W'(TRIM_RST);
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: if (start) st <= S_ARM;
          S_ARM: if (ref_rise) begin
            cnt <= '0;
            st  <= S_MEAS;
          end
          S_MEAS: begin
            if (!cnt_sat) cnt <= cnt + 1'b1;
            if (ref_rise) st <= S_ADJ;
          end
          S_ADJ: begin
            if (step_dn)      trim <= trim - 1'b1;
            else if (step_up) trim <= trim + 1'b1;
            if (mode_interval && !moved) begin
              st  <= S_IDLE;
              irq <= irq_en;
            end else st <= S_ARM;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module osc_trim_cal_chk #(
  parameter int TRIM_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              irq_en,
  input logic              busy,
  input logic [TRIM_W-1:0] trim,
  input logic              irq
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !busy) |=> busy);
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
  // R7
  irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
  // R5
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));
  // R11
  trim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> $past(busy));
  // R11
  trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> ((trim == $past(trim) + 1'b1) || (trim == $past(trim) - 1'b1)));
endmodule

bind osc_trim_cal osc_trim_cal_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .irq_en(irq_en),
  .busy(busy), .trim(trim), .irq(irq));

// File: tb/osc_trim_cal_bench.sv
module osc_trim_cal_bench;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int TW = 7;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic start = 1'b0, stop = 1'b0, mode_interval = 1'b1, irq_en = 1'b0;
  logic [CW-1:0] win_lo = '0, win_hi = '0;
  logic busy, irq;
  logic [TW-1:0] trim;
  int checks = 0, failures = 0, irq_cnt = 0, extra = 0;

  osc_trim_cal #(.CNT_W(CW), .TRIM_W(TW), .TRIM_RST(64)) u_osc_trim_cal (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .start(start), .stop(stop),
    .mode_interval(mode_interval), .irq_en(irq_en), .win_lo(win_lo),
    .win_hi(win_hi), .busy(busy), .trim(trim), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (irq) irq_cnt++;

  initial begin
    forever begin
      int p;
      p = 100 + int'(trim) + extra;
      ref_clk = 1'b1;
      repeat (p/2) @(negedge clk);
      ref_clk = 1'b0;
      repeat (p - p/2) @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  task automatic do_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(busy === 1'b0, "R10 busy after stop", int'(busy), 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy === 1'b1 && n < 60000) begin
      @(negedge clk);
      n++;
    end
    chk(busy === 1'b0, "R5 self stop", int'(busy), 0);
  endtask

  task automatic run_interval(input int lo, input int hi, input bit en,
                              input int exp_trim, input int exp_irq, input string req);
    @(negedge clk);
    mode_interval = 1'b1; irq_en = en;
    win_lo = CW'(lo); win_hi = CW'(hi);
    irq_cnt = 0;
    pulse_start();
    wait_idle();
    repeat (3) @(negedge clk);
    chk(trim == TW'(exp_trim), req, int'(trim), exp_trim);
    chk(irq_cnt == exp_irq, "R7 irq count", irq_cnt, exp_irq);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(irq === 1'b0, "R1 irq", int'(irq), 0);
    chk(trim === 7'd64, "R1 trim", int'(trim), 64);
  endtask

  task automatic t_counter_sat();
    int n = 0;
    extra = 200;
    @(negedge clk);
    mode_interval = 1'b0; irq_en = 1'b1;
    win_lo = 8'd0; win_hi = 8'd255;
    irq_cnt = 0;
    pulse_start();
    while (trim == 7'd127 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(trim == 7'd126, "R8 saturated count steps down", int'(trim), 126);
    do_stop();
    extra = 0;
    repeat (600) @(negedge clk);
    chk(trim == 7'd126, "R10 trim kept after stop", int'(trim), 126);
    chk(irq_cnt == 0, "R10 no irq on stop", irq_cnt, 0);
  endtask

  task automatic t_continuous();
    @(negedge clk);
    mode_interval = 1'b0; irq_en = 1'b1;
    win_lo = 8'd220; win_hi = 8'd230;
    irq_cnt = 0;
    pulse_start();
    repeat (1500) @(negedge clk);
    chk(busy === 1'b1, "R9 still busy", int'(busy), 1);
    chk(trim == 7'd126, "R9 trim held", int'(trim), 126);
    chk(irq_cnt == 0, "R9 no irq", irq_cnt, 0);
    do_stop();
  endtask

  initial begin
    #(CLK_P * 190000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_interval(150, 152, 1'b1, 52, 1, "R3 R4 converge down");
    run_interval(170, 172, 1'b0, 70, 0, "R4 converge up no irq");
    run_interval(165, 175, 1'b1, 70, 1, "R4 already in window");
    run_interval(0, 10, 1'b1, 0, 1, "R6 low limit");
    run_interval(240, 250, 1'b1, 127, 1, "R6 high limit");
    t_counter_sat();
    t_continuous();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule